// File: doc/BRIEF.md
# Oscillator Tuning Register Write Port

This block is the processor-facing load path for a numerically controlled oscillator. A host drives a 16-bit data bus and a 3-bit address, then pulses an active-low write strobe. The block holds two 32-bit frequency tuning words and four 12-bit phase offset words. It presents all six words to the oscillator core as plain outputs. There is no read-back path.

Everything runs on the master clock. The strobe is sampled on each rising clock edge. The first edge that sees the strobe high, after an edge that saw it low, is the strobe's rising transition. On that edge the data and address present at the edge are committed into the addressed word.

A frequency word is loaded as two independent 16-bit halves. Each half lands on its own, with no shadow copy of the other half. A phase word keeps only the low 12 data bits. The active-low reset clears only the strobe edge tracker, so the tuning words keep whatever they held.

Top module: `nco_reg_port`

## Requirements
- R1: A write is committed on the first rising clock edge at which the strobe is sampled high after having been sampled low on the previous edge. Before that edge the outputs keep their old values. After it the new value is visible.
- R2: Address 3'b000 loads `freq0[15:0]` and address 3'b001 loads `freq0[31:16]`, each from `data[15:0]`.
- R3: Address 3'b010 loads `freq1[15:0]` and address 3'b011 loads `freq1[31:16]`, each from `data[15:0]`.
- R4: Addresses 3'b100, 3'b101, 3'b110 and 3'b111 load `phase0`, `phase1`, `phase2` and `phase3` from `data[11:0]`.
- R5: `data[15:12]` has no effect on a phase word write.
- R6: A write changes only the addressed half or phase word. Every other output bit is left unchanged, including the other half of the same frequency word.
- R7: While the strobe is held low, or held high, for any number of cycles, no output changes.
- R8: Reset does not alter any stored word. A strobe edge that occurs while reset is low is not committed, and releasing reset with the strobe high causes no write.
- R9: Back-to-back writes, with the strobe low for one cycle and high for one cycle, are each committed in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the strobe edge tracker only |
| wr_n | input | 1 | Active-low write strobe; a commit follows its rise |
| addr | input | 3 | Destination select |
| data | input | 16 | Write data |
| freq0 | output | 32 | Frequency tuning word 0 |
| freq1 | output | 32 | Frequency tuning word 1 |
| phase0 | output | 12 | Phase offset word 0 |
| phase1 | output | 12 | Phase offset word 1 |
| phase2 | output | 12 | Phase offset word 2 |
| phase3 | output | 12 | Phase offset word 3 |

## Verification
The main function is tried with writes to all eight addresses in a shuffled order, using random data. Comparing a full snapshot of all six words after each write separates a wrong address decode from a write that spills into a neighbouring half.

Phase writes carry both set and clear top nibbles, which shows whether bits 15:12 leak in. Separate patterns cover:
- a strobe held low for several cycles, which shows no level-triggered loading;
- one-cycle back-to-back pulses, which show no lost or merged commits;
- strobe edges made under reset, which show no commit and no clearing of the words.

// File: rtl/nco_reg_port.sv
module nco_reg_port #(
  parameter int HALF_W  = 16,
  parameter int PHASE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_n,
  input  logic [2:0]            addr,
  input  logic [HALF_W-1:0]     data,
  output logic [2*HALF_W-1:0]   freq0,
  output logic [2*HALF_W-1:0]   freq1,
  output logic [PHASE_W-1:0]    phase0,
  output logic [PHASE_W-1:0]    phase1,
  output logic [PHASE_W-1:0]    phase2,
  output logic [PHASE_W-1:0]    phase3
);
  logic                wr_q;
  logic                commit;
  logic [HALF_W-1:0]   f0_lo, f0_hi, f1_lo, f1_hi;
  logic [PHASE_W-1:0]  ph [4];

  always_ff @(posedge clk) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  assign commit = rst_n & wr_n & ~wr_q;

  always_ff @(posedge clk) begin
    if (commit) begin
      case (addr)
        3'd0: f0_lo <= data;
        3'd1: f0_hi <= data;
        3'd2: f1_lo <= data;
        3'd3: f1_hi <= data;
        default: ph[addr[1:0]] <= data[PHASE_W-1:0];
      endcase
    end
  end

  assign freq0  = {f0_hi, f0_lo};
  assign freq1  = {f1_hi, f1_lo};
  assign phase0 = ph[0];
  assign phase1 = ph[1];
  assign phase2 = ph[2];
  assign phase3 = ph[3];
endmodule

// File: rtl/nco_reg_port_chk.sv
module nco_reg_port_chk #(
  parameter int HALF_W  = 16,
  parameter int PHASE_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_n,
  input logic [2:0]          addr,
  input logic [HALF_W-1:0]   data,
  input logic [2*HALF_W-1:0] freq0,
  input logic [2*HALF_W-1:0] freq1,
  input logic [PHASE_W-1:0]  phase0,
  input logic [PHASE_W-1:0]  phase1,
  input logic [PHASE_W-1:0]  phase2,
  input logic [PHASE_W-1:0]  phase3
);
  logic seen_hi;
  logic rise;
  logic [PHASE_W-1:0] pv [4];

  always_ff @(posedge clk) begin
    if (!rst_n) seen_hi <= 1'b1;
    else        seen_hi <= wr_n;
  end
  assign rise  = wr_n && !seen_hi;
  assign pv[0] = phase0;
  assign pv[1] = phase1;
  assign pv[2] = phase2;
  assign pv[3] = phase3;

  AST_FREQ0_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rise && addr == 3'd0 |=> freq0[HALF_W-1:0] == $past(data)); // R2
  AST_FREQ0_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rise && addr == 3'd1 |=> freq0[2*HALF_W-1:HALF_W] == $past(data)); // R2
  AST_FREQ1_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rise && addr == 3'd2 |=> freq1[HALF_W-1:0] == $past(data)); // R3
  AST_FREQ1_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rise && addr == 3'd3 |=> freq1[2*HALF_W-1:HALF_W] == $past(data)); // R3
  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rise && addr[2] |=> pv[$past(addr[1:0])] == $past(data[PHASE_W-1:0])); // R4 R5
  AST_HALF_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    rise && addr == 3'd0 |=> freq0[2*HALF_W-1:HALF_W] === $past(freq0[2*HALF_W-1:HALF_W])
                            && freq1 === $past(freq1)); // R6
  AST_PHASE_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    rise && addr[2] |=> freq0 === $past(freq0) && freq1 === $past(freq1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> freq0 === $past(freq0) && freq1 === $past(freq1)
              && phase0 === $past(phase0) && phase1 === $past(phase1)
              && phase2 === $past(phase2) && phase3 === $past(phase3)); // R7
endmodule

bind nco_reg_port nco_reg_port_chk #(.HALF_W(HALF_W), .PHASE_W(PHASE_W)) i_chk (.*);

// File: tb/test_nco_reg_port.sv
module test_nco_reg_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [15:0] data = '0;
  logic [31:0] freq0, freq1;
  logic [11:0] phase0, phase1, phase2, phase3;

  nco_reg_port i_nco_reg_port (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .data(data),
    .freq0(freq0), .freq1(freq1),
    .phase0(phase0), .phase1(phase1), .phase2(phase2), .phase3(phase3)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] f0, f1;
    logic [11:0] p [4];
    int          due;
    string       req;
  } item_t;

  item_t       q[$];
  logic [31:0] m_f0, m_f1;
  logic [11:0] m_p [4];
  int          checks = 0, fails = 0, cyc = 0;
  bit          armed = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req, logic [31:0] f0, logic [31:0] f1,
                         logic [11:0] p0, logic [11:0] p1, logic [11:0] p2, logic [11:0] p3);
    chk(freq0 === f0 && freq1 === f1 && phase0 === p0 && phase1 === p1 &&
        phase2 === p2 && phase3 === p3, req, "snapshot freq0", freq0, f0);
    if (freq1 !== f1)   $display("  detail freq1 actual=%h expected=%h", freq1, f1);
    if (phase0 !== p0)  $display("  detail phase0 actual=%h expected=%h", phase0, p0);
    if (phase1 !== p1)  $display("  detail phase1 actual=%h expected=%h", phase1, p1);
    if (phase2 !== p2)  $display("  detail phase2 actual=%h expected=%h", phase2, p2);
    if (phase3 !== p3)  $display("  detail phase3 actual=%h expected=%h", phase3, p3);
  endtask

  task automatic model(logic [2:0] a, logic [15:0] d);
    case (a)
      3'd0: m_f0[15:0]  = d;
      3'd1: m_f0[31:16] = d;
      3'd2: m_f1[15:0]  = d;
      3'd3: m_f1[31:16] = d;
      default: m_p[a[1:0]] = d[11:0];
    endcase
  endtask

  task automatic push(string req);
    item_t it;
    it.f0 = m_f0; it.f1 = m_f1;
    for (int k = 0; k < 4; k++) it.p[k] = m_p[k];
    it.due = cyc + 1;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d, string req);
    @(negedge clk); wr_n = 1'b0; addr = a; data = d;
    @(negedge clk); wr_n = 1'b1;
    model(a, d);
    if (armed) push(req);
  endtask

  task automatic snap(string req);
    compare(req, m_f0, m_f1, m_p[0], m_p[1], m_p[2], m_p[3]);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        compare(it.req, it.f0, it.f1, it.p[0], it.p[1], it.p[2], it.p[3]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int order [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) wr(3'(a), 16'h1111 * 16'(a + 1), "init");
    repeat (2) @(negedge clk);
    snap("R1 R2 R3 R4 init");
    armed = 1;

    // R1: before the commit edge the outputs hold; after it they change
    @(negedge clk); wr_n = 1'b0; addr = 3'd2; data = 16'hBEEF;
    @(negedge clk); wr_n = 1'b1;
    #1 snap("R1 before commit");
    model(3'd2, 16'hBEEF);
    @(negedge clk); snap("R1 after commit");

    // R2 R3 R4 R6: every address, shuffled order, random data
    for (int i = 0; i < 8; i++) order[i] = i;
    for (int i = 7; i > 0; i--) begin
      int j, t;
      j = int'($urandom_range(i, 0));
      t = order[i]; order[i] = order[j]; order[j] = t;
    end
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 8; i++)
        wr(3'(order[i]), 16'($urandom),
           order[i] < 2 ? "R2/R6" : (order[i] < 4 ? "R3/R6" : "R4/R6"));

    // R5: top nibble set or clear must not matter for phase words
    for (int k = 0; k < 4; k++) begin
      wr(3'(4 + k), {4'hF, 12'h5A0 + 12'(k)}, "R5");
      wr(3'(4 + k), {4'h0, 12'hA50 + 12'(k)}, "R5");
    end

    // R7: strobe held low then held high
    @(negedge clk); wr_n = 1'b0; addr = 3'd1; data = 16'hC0DE;
    repeat (5) @(negedge clk);
    snap("R7 held low");
    wr_n = 1'b1;
    model(3'd1, 16'hC0DE);
    push("R7 release");
    repeat (5) @(negedge clk);
    snap("R7 held high");

    // R9: back-to-back single-cycle pulses
    wr(3'd0, 16'h0001, "R9");
    wr(3'd1, 16'h0002, "R9");
    wr(3'd0, 16'h0003, "R9");
    wr(3'd7, 16'hF004, "R9");
    wr(3'd3, 16'h0005, "R9");
    repeat (2) @(negedge clk);

    // R8: strobe activity under reset neither commits nor clears
    @(negedge clk); wr_n = 1'b0; addr = 3'd4; data = 16'h0999;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); wr_n = 1'b0; addr = 3'd0; data = 16'h7777;
    @(negedge clk); wr_n = 1'b1;
    repeat (2) @(negedge clk);
    snap("R8 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    snap("R8 after reset release");
    wr(3'd5, 16'h0123, "R8 write after reset");

    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule